// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends characters over an asynchronous serial line. A character is written into a holding buffer. The hardware moves it into a shift register as soon as the shifter is free, so the next character can be written while the current one is still going out. A frame is a low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop bit. When parity is enabled, the parity bit takes the place of the top data bit, so the frame length does not change.

The bit rate comes from the bus clock. A programmable divisor (`baud_div`) produces an oversampling tick, and 16 of those ticks make one bit time. Two flags report progress. `buf_empty` shows that the holding buffer can take a new character. `tx_done` shows that the line has gone idle with nothing left to send. Each flag has its own interrupt enable. A break control holds the line low for whole character times. A loopback switch sends the serial stream to the receiver input instead of the pin.

Top module: `uart_dbl_tx`

## Requirements
- R1: After reset, `txd` is high, `buf_empty` is 1 and `tx_done` is 1.
- R2: The serial line shows line bit 0 = 0 (start), then the data bits least significant first, then 1 (stop). With `nine_bit`=0 a frame is 10 bits long: start, data bits 0..7, stop.
- R3: Each bit lasts exactly 16 × `baud_div` clock cycles. The start bit begins on the clock edge after the write edge when the shifter is idle and `tx_en`=1.
- R4: With `nine_bit`=1 a frame is 11 bits long, and `wr_bit8` supplies data bit 8, which is sent in line position 9.
- R5: With `par_en`=1, the top data slot (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries the XOR of the lower data bits. That XOR is inverted when `par_odd`=1.
- R6: A write makes `buf_empty` 0 from the next cycle on. The transfer into the shifter sets it back to 1.
- R7: A character written while a frame is going out is held, and its start bit follows the previous stop bit with no idle cycle. A write in the same cycle as a transfer is kept as the next character.
- R8: A write or a frame start clears `tx_done`. `tx_done` becomes 1 on the edge where a stop bit ends while the buffer is empty.
- R9: While `tx_en`=0 no transfer takes place, `txd` stays high and the buffered character is kept.
- R10: While `send_brk`=1, all-zero frames of the current frame length are sent back to back, taking priority over a buffered character. That character follows once the break is released.
- R11: With `loop_en`=1, `txd` is held high and `rcv_in` carries the serial stream. With `loop_en`=0, `rcv_in` follows `rxd_pin`.
- R12: `irq_empty` = `buf_empty` AND `empty_ie`; `irq_done` = `tx_done` AND `done_ie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| par_en | input | 1 | Parity insertion enable |
| par_odd | input | 1 | 1 odd parity, 0 even parity |
| send_brk | input | 1 | Send break characters |
| loop_en | input | 1 | Route serial stream to the receiver input |
| baud_div | input | DIV_W | Clock divisor for the oversampling tick (0 halts) |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Data bits 7..0 |
| wr_bit8 | input | 1 | Data bit 8 for 9-bit mode |
| empty_ie | input | 1 | Buffer-empty interrupt enable |
| done_ie | input | 1 | Transmission-complete interrupt enable |
| rxd_pin | input | 1 | External receive pin |
| txd | output | 1 | Serial output pin |
| rcv_in | output | 1 | Serial input toward the receiver |
| buf_empty | output | 1 | Holding buffer empty flag |
| tx_done | output | 1 | Transmission complete flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_done | output | 1 | Transmission-complete interrupt request |

## Verification
The bench builds the block with its default parameters: a 13-bit divisor and 16 ticks per bit. At run time it sets `baud_div` to 1 and 3, which makes frames 160 to 528 cycles long. At that length every bit of every frame can be sampled at its midpoint, and the end of the stop bit can be checked to the exact clock. The two divisor values show that bit time scales with the divisor. Back-to-back frames, a break running into a queued character, and a write that lands on the transfer edge all fall within a few thousand cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    localparam int FRAME_W = 11;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } tx_fmt_t;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } tx_state_t;

    // Line image, bit 0 goes out first: start, data (parity in top slot), stop.
    function automatic logic [FRAME_W-1:0] build_frame(input logic [8:0] d, input tx_fmt_t f);
        logic [FRAME_W-1:0] r;
        r    = '1;
        r[0] = 1'b0;
        if (f.nine) begin
            r[9:1] = d;
            if (f.par_en) r[9] = (^d[7:0]) ^ f.par_odd;
        end else begin
            r[8:1] = d[7:0];
            if (f.par_en) r[8] = (^d[6:0]) ^ f.par_odd;
        end
        return r;
    endfunction

    function automatic logic [3:0] frame_len(input logic nine);
        return nine ? 4'd11 : 4'd10;
    endfunction
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (div != '0) && (cnt == div - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
    import uart_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    input  logic [3:0]         len,
    output logic               busy,
    output logic               line,
    output logic               frame_end
);
    localparam int OVS_W = $clog2(OVS);
    localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);

    tx_state_t          state;
    logic [FRAME_W-1:0] sh;
    logic [OVS_W-1:0]   sub;
    logic [3:0]         bitn;
    logic [3:0]         len_q;
    logic               bit_done;

    assign busy      = (state == ST_SHIFT);
    assign line      = busy ? sh[0] : 1'b1;
    assign bit_done  = busy && tick && (sub == SUB_LAST);
    assign frame_end = bit_done && (bitn == len_q - 4'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            sh    <= '1;
            sub   <= '0;
            bitn  <= '0;
            len_q <= '0;
        end else if (load) begin
            state <= ST_SHIFT;
            sh    <= frame;
            sub   <= '0;
            bitn  <= '0;
            len_q <= len;
        end else if (busy && tick) begin
            if (bit_done) begin
                sub <= '0;
                if (frame_end) begin
                    state <= ST_IDLE;
                end else begin
                    bitn <= bitn + 4'd1;
                    sh   <= {1'b1, sh[FRAME_W-1:1]};
                end
            end else begin
                sub <= sub + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_dbl_tx.sv
module uart_dbl_tx
    import uart_tx_pkg::*;
#(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             nine_bit,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             send_brk,
    input  logic             loop_en,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             wr_stb,
    input  logic [7:0]       wr_data,
    input  logic             wr_bit8,
    input  logic             empty_ie,
    input  logic             done_ie,
    input  logic             rxd_pin,
    output logic             txd,
    output logic             rcv_in,
    output logic             buf_empty,
    output logic             tx_done,
    output logic             irq_empty,
    output logic             irq_done
);
    logic [8:0]         hold_q;
    logic               empty_q;
    logic               done_q;
    logic               busy;
    logic               line;
    logic               frame_end;
    logic               tick;
    logic               load;
    logic               take;
    tx_fmt_t            fmt;
    logic [FRAME_W-1:0] frame;

    assign fmt   = '{nine: nine_bit, par_en: par_en, par_odd: par_odd};
    assign load  = tx_en && (!busy || frame_end) && (send_brk || !empty_q);
    assign take  = load && !send_brk;
    assign frame = send_brk ? '0 : build_frame(hold_q, fmt);

    uart_tx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (baud_div),
        .tick (tick)
    );

    uart_tx_shift #(.OVS(OVS)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (load),
        .frame     (frame),
        .len       (frame_len(nine_bit)),
        .busy      (busy),
        .line      (line),
        .frame_end (frame_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q  <= '0;
            empty_q <= 1'b1;
            done_q  <= 1'b1;
        end else begin
            if (take) empty_q <= 1'b1;
            if (wr_stb) begin
                hold_q  <= {wr_bit8, wr_data};
                empty_q <= 1'b0;
            end
            if (wr_stb || load)            done_q <= 1'b0;
            else if (frame_end && empty_q) done_q <= 1'b1;
        end
    end

    assign txd       = loop_en ? 1'b1 : line;
    assign rcv_in    = loop_en ? line : rxd_pin;
    assign buf_empty = empty_q;
    assign tx_done   = done_q;
    assign irq_empty = empty_q && empty_ie;
    assign irq_done  = done_q && done_ie;
endmodule

// File: rtl/uart_dbl_tx_chk.sv
module uart_dbl_tx_chk (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic wr_stb,
    input logic loop_en,
    input logic send_brk,
    input logic txd,
    input logic line,
    input logic busy,
    input logic buf_empty,
    input logic tx_done
);
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !buf_empty); // R6

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !buf_empty && !wr_stb) |=> !buf_empty); // R9

    AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> txd); // R11

    AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !tx_done); // R8

    AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> !busy); // R8

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !line); // R2

    AST_BREAK_STARTS: assert property (@(posedge clk) disable iff (rst)
        (send_brk && tx_en && !busy) |=> (busy && !line)); // R10
endmodule

bind uart_dbl_tx uart_dbl_tx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .wr_stb    (wr_stb),
    .loop_en   (loop_en),
    .send_brk  (send_brk),
    .txd       (txd),
    .line      (line),
    .busy      (busy),
    .buf_empty (buf_empty),
    .tx_done   (tx_done)
);

// File: tb/uart_dbl_tx_tb.sv
module uart_dbl_tx_tb;
    localparam int DIV_W = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tx_en = 1'b0, nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic             send_brk = 1'b0, loop_en = 1'b0;
    logic [DIV_W-1:0] baud_div = 13'd1;
    logic             wr_stb = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             wr_bit8 = 1'b0;
    logic             empty_ie = 1'b0, done_ie = 1'b0, rxd_pin = 1'b1;
    logic             txd, rcv_in, buf_empty, tx_done, irq_empty, irq_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    uart_dbl_tx #(.DIV_W(DIV_W), .OVS(16)) u_dut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .nine_bit(nine_bit), .par_en(par_en),
        .par_odd(par_odd), .send_brk(send_brk), .loop_en(loop_en), .baud_div(baud_div),
        .wr_stb(wr_stb), .wr_data(wr_data), .wr_bit8(wr_bit8), .empty_ie(empty_ie),
        .done_ie(done_ie), .rxd_pin(rxd_pin), .txd(txd), .rcv_in(rcv_in),
        .buf_empty(buf_empty), .tx_done(tx_done), .irq_empty(irq_empty), .irq_done(irq_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [8:0] d, input bit nine, input bit pe, input bit po);
        logic [10:0] r;
        int  nd = nine ? 9 : 8;
        bit  p  = po;
        r = '1;
        r[0] = 1'b0;
        for (int i = 0; i < nd - 1; i++) p ^= d[i];
        for (int i = 0; i < nd; i++) r[i + 1] = (pe && i == nd - 1) ? p : d[i];
        return r;
    endfunction

    task automatic wr(input logic [8:0] d);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = d[7:0]; wr_bit8 = d[8];
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    // Waits for a start bit, then samples each bit at its midpoint; returns at the
    // negedge just after the edge where the last bit ends.
    task automatic grab(input int nb, input int div, input bit lp,
                        output logic [10:0] got, output bit pin_low);
        int  b = 16 * div;
        bit  seen = 1'b0;
        got = '1;
        pin_low = 1'b0;
        for (int w = 0; w < 300; w++) begin
            if ((lp ? rcv_in : txd) == 1'b0) begin seen = 1'b1; break; end
            @(negedge clk);
        end
        if (!seen) chk("R2 start bit seen", 0, 1);
        repeat (b / 2) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            if (k > 0) repeat (b) @(negedge clk);
            got[k] = lp ? rcv_in : txd;
            if (lp && !txd) pin_low = 1'b1;
        end
        chk("R8 tx_done low mid-frame", tx_done, 0);
        repeat (b / 2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 txd idle", txd, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 tx_done", tx_done, 1);
        chk("R12 irq_empty off", irq_empty, 0);
        chk("R12 irq_done off", irq_done, 0);
    endtask

    task automatic t_basic();
        logic [10:0] g; bit pl;
        baud_div = 13'd1; tx_en = 1'b1;
        wr(9'h0A5);
        chk("R6 buffer full after write", buf_empty, 0);
        @(negedge clk);
        chk("R6 empty after transfer", buf_empty, 1);
        chk("R3 start bit one edge after write", txd, 0);
        grab(10, 1, 1'b0, g, pl);
        chk("R2 8-bit frame", g, exp_frame(9'h0A5, 0, 0, 0));
        chk("R8 done at stop end", tx_done, 1);
        chk("R3 line idle after frame", txd, 1);
    endtask

    task automatic t_nine();
        logic [10:0] g; bit pl;
        baud_div = 13'd3; nine_bit = 1'b1;
        wr(9'h13C);
        grab(11, 3, 1'b0, g, pl);
        chk("R4 9-bit frame", g, exp_frame(9'h13C, 1, 0, 0));
        chk("R3 R8 done at 11*48 clocks", tx_done, 1);
        nine_bit = 1'b0; baud_div = 13'd1;
    endtask

    task automatic t_parity();
        logic [10:0] g; bit pl;
        par_en = 1'b1; par_odd = 1'b0;
        wr(9'h007);
        grab(10, 1, 1'b0, g, pl);
        chk("R5 even parity 8-bit", g, exp_frame(9'h007, 0, 1, 0));
        par_odd = 1'b1; nine_bit = 1'b1;
        wr(9'h0F0);
        grab(11, 1, 1'b0, g, pl);
        chk("R5 odd parity 9-bit", g, exp_frame(9'h0F0, 1, 1, 1));
        par_en = 1'b0; par_odd = 1'b0; nine_bit = 1'b0;
    endtask

    task automatic t_double();
        logic [10:0] g; bit pl;
        wr(9'h0C3);
        wr_stb = 1'b1; wr_data = 8'h5A; wr_bit8 = 1'b0;   // lands on the transfer edge
        @(negedge clk);
        wr_stb = 1'b0;
        chk("R7 write on transfer edge kept", buf_empty, 0);
        grab(10, 1, 1'b0, g, pl);
        chk("R7 first frame", g, exp_frame(9'h0C3, 0, 0, 0));
        chk("R7 no done between frames", tx_done, 0);
        chk("R7 next start without gap", txd, 0);
        chk("R6 empty after second transfer", buf_empty, 1);
        grab(10, 1, 1'b0, g, pl);
        chk("R7 second frame", g, exp_frame(9'h05A, 0, 0, 0));
        chk("R8 done after last frame", tx_done, 1);
    endtask

    task automatic t_disable();
        logic [10:0] g; bit pl; bit low = 1'b0;
        tx_en = 1'b0;
        wr(9'h066);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!txd) low = 1'b1;
        end
        chk("R9 line stays high", low, 0);
        chk("R9 buffer kept", buf_empty, 0);
        chk("R8 done cleared by write", tx_done, 0);
        tx_en = 1'b1;
        @(negedge clk);
        grab(10, 1, 1'b0, g, pl);
        chk("R9 held character sent after enable", g, exp_frame(9'h066, 0, 0, 0));
    endtask

    task automatic t_break();
        logic [10:0] g; bit pl;
        send_brk = 1'b1;
        @(negedge clk);
        fork
            grab(10, 1, 1'b0, g, pl);
            begin repeat (40) @(negedge clk); wr(9'h0E1); end
        join
        chk("R10 break frame all low", g, 11'h400);
        chk("R10 break repeats over pending data", txd, 0);
        send_brk = 1'b0;
        grab(10, 1, 1'b0, g, pl);
        chk("R10 second break frame", g, 11'h400);
        chk("R10 data follows break", txd, 0);
        grab(10, 1, 1'b0, g, pl);
        chk("R10 queued character after break", g, exp_frame(9'h0E1, 0, 0, 0));
    endtask

    task automatic t_loop();
        logic [10:0] g; bit pl;
        rxd_pin = 1'b0;
        @(negedge clk);
        chk("R11 rcv_in follows pin", rcv_in, 0);
        loop_en = 1'b1;
        @(negedge clk);
        chk("R11 rcv_in idle high in loop", rcv_in, 1);
        wr(9'h09B);
        grab(10, 1, 1'b1, g, pl);
        chk("R11 looped frame", g, exp_frame(9'h09B, 0, 0, 0));
        chk("R11 pin quiet in loop", pl, 0);
        loop_en = 1'b0; rxd_pin = 1'b1;
    endtask

    task automatic t_irq();
        logic [10:0] g; bit pl;
        empty_ie = 1'b1; done_ie = 1'b1;
        @(negedge clk);
        chk("R12 irq_empty idle", irq_empty, 1);
        chk("R12 irq_done idle", irq_done, 1);
        tx_en = 1'b0;
        wr(9'h011);
        chk("R12 irq_empty drops", irq_empty, 0);
        chk("R12 irq_done drops", irq_done, 0);
        done_ie = 1'b0;
        tx_en = 1'b1;
        @(negedge clk);
        chk("R12 irq_empty on transfer", irq_empty, 1);
        grab(10, 1, 1'b0, g, pl);
        chk("R12 irq_done masked", irq_done, 0);
        empty_ie = 1'b0;
        @(negedge clk);
        chk("R12 irq_empty masked", irq_empty, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nine();
        t_parity();
        t_double();
        t_disable();
        t_break();
        t_loop();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule